// File: doc/BRIEF.md
# Differential Constellation Mapper

This block turns the data bits of one modem symbol into a single point on the complex plane. The point is a signed in-phase byte and a signed quadrature byte. The bits do not name the point itself. They name a change of phase in 45-degree steps. The block keeps the absolute phase of the last point and adds each new change to it. It then reads the point's coordinates from the new absolute phase and from an amplitude choice.

Three symbol sizes are supported. Four-bit symbols give eight phase changes plus a bit that selects one of two amplitudes. Three-bit symbols are a fallback that always uses the lower amplitude. Two-bit symbols give four phase changes at one constant amplitude. A symbol strobe starts each conversion. The result appears on the next cycle together with a one-cycle valid pulse, and it stays on the outputs until the next symbol. A typical use is driving an X-Y display of received or transmitted points, or feeding the next stage of a transmitter.

Top module: `dpsk_point_mapper`

## Requirements
- R1: Reset clears the absolute phase to 0 and drives outI=0, outQ=0 and outValid=0. The first symbol after reset with a zero phase change therefore lands at phase 0.
- R2: outValid is high for exactly the cycle that follows each accepted strobe and is low otherwise. The outI/outQ outputs change only when outValid rises, and they hold their value between symbols.
- R3: When symMode=2'b00 (four-bit), symBits[2:0] is the three-bit phase code, with bit 2 as the earliest bit in time. The phase change for each code is 001 → 0, 000 → 1, 010 → 2, 011 → 3, 111 → 4, 110 → 5, 100 → 6 and 101 → 7, counted in 45-degree steps.
- R4: When the new absolute phase lies on an axis (an even step count), the point has a magnitude of 48 if symBits[3]=0 and 80 if symBits[3]=1. These are amplitudes 3 and 5 scaled by 16.
- R5: When the new absolute phase lies on a diagonal (an odd step count), both components have a magnitude of 16 if symBits[3]=0 and 48 if symBits[3]=1.
- R6: The absolute phase is a count of 45-degree steps kept modulo 8, and each accepted symbol adds its phase change to it.
- R7: When symMode=2'b01 (three-bit), symBits[2:0] is decoded with the R3 table. symBits[3] is ignored and the lower amplitude is always used.
- R8: When symMode=2'b10 (two-bit), symBits[1:0] sets the phase change: 00 → 0, 01 → 2, 11 → 4, 10 → 6 steps. symBits[3:2] are ignored. Every nonzero component has a magnitude of 16.
- R9: When symMode=2'b11 (reserved), a strobe is ignored. No valid pulse follows, the outputs keep their values and the absolute phase does not change.
- R10: The signs follow the phase. Step 0 gives (+a,0), 1 gives (+d,+d), 2 gives (0,+a), 3 gives (-d,+d), 4 gives (-a,0), 5 gives (-d,-d), 6 gives (0,-a) and 7 gives (+d,-d).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| symMode | input | 2 | Symbol size: 00 four-bit, 01 three-bit, 10 two-bit, 11 reserved |
| symBits | input | 4 | Symbol bits; bit 3 is the amplitude bit in four-bit mode |
| symValid | input | 1 | Symbol strobe, one cycle per symbol |
| outI | output | DATA_W | In-phase coordinate, two's complement |
| outQ | output | DATA_W | Quadrature coordinate, two's complement |
| outValid | output | 1 | One-cycle pulse marking a new point |

## Verification
The properties assume that symMode is sampled on the same edge as symValid, so the mode seen one cycle before a valid pulse belongs to that pulse's symbol. They also assume that reset is asserted from time zero. The stimulus meets both assumptions: mode, bits and strobe change together on the falling edge, and all three hold for a whole cycle. Reset is low from the start of the run. The sequences include back-to-back strobes, walks through every phase code, and wrap-around in both directions. They also include mode changes in mid-stream from both axis and diagonal phases, and a reserved-mode strobe followed by a symbol that shows the phase did not move.

// File: rtl/dpsk_map_pkg.sv
package dpsk_map_pkg;

  localparam int PHASE_STEPS = 8;
  localparam int PHASE_W     = $clog2(PHASE_STEPS);

  typedef enum logic [1:0] {
    MODE_QUAD = 2'b00,
    MODE_TRI  = 2'b01,
    MODE_DI   = 2'b10,
    MODE_RSVD = 2'b11
  } symMode_e;

  typedef enum logic [1:0] {
    LVL_UNIT = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2
  } level_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic               advance;
    logic [PHASE_W-1:0] step;
    level_e             level;
  } mapStrobe_t;

  // Three-bit phase code to 45-degree step count (non-binary order)
  function automatic logic [PHASE_W-1:0] tribitStep(input logic [2:0] code);
    logic [PHASE_W-1:0] s;
    case (code)
      3'b001:  s = 3'd0;
      3'b000:  s = 3'd1;
      3'b010:  s = 3'd2;
      3'b011:  s = 3'd3;
      3'b111:  s = 3'd4;
      3'b110:  s = 3'd5;
      3'b100:  s = 3'd6;
      default: s = 3'd7;
    endcase
    return s;
  endfunction

  // Two-bit phase code to 45-degree step count (quarter turns)
  function automatic logic [PHASE_W-1:0] dibitStep(input logic [1:0] code);
    logic [PHASE_W-1:0] s;
    case (code)
      2'b00:   s = 3'd0;
      2'b01:   s = 3'd2;
      2'b11:   s = 3'd4;
      default: s = 3'd6;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dpsk_map_ctrl.sv
module dpsk_map_ctrl
  import dpsk_map_pkg::*;
(
  input  logic       symValid,
  input  logic [1:0] symMode,
  input  logic [3:0] symBits,
  output mapStrobe_t strobe
);

  symMode_e modeSel;
  assign modeSel = symMode_e'(symMode);

  always_comb begin
    strobe.advance = 1'b0;
    strobe.step    = '0;
    strobe.level   = LVL_UNIT;
    case (modeSel)
      MODE_QUAD: begin
        strobe.advance = symValid;
        strobe.step    = tribitStep(symBits[2:0]);
        if (symBits[3]) strobe.level = LVL_HIGH;
        else            strobe.level = LVL_LOW;
      end
      MODE_TRI: begin
        strobe.advance = symValid;
        strobe.step    = tribitStep(symBits[2:0]);
        strobe.level   = LVL_LOW;
      end
      MODE_DI: begin
        strobe.advance = symValid;
        strobe.step    = dibitStep(symBits[1:0]);
        strobe.level   = LVL_UNIT;
      end
      default: begin
        strobe.advance = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dpsk_map_axis.sv
// One coordinate of the point: the cosine-like component of the phase
// rotated back by OFFSET steps (OFFSET=2 yields the quadrature part).
module dpsk_map_axis
  import dpsk_map_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SCALE_SHIFT = 4,
  parameter int OFFSET      = 0
) (
  input  logic [PHASE_W-1:0]        phase,
  input  level_e                    level,
  output logic signed [DATA_W-1:0]  comp
);

  localparam logic signed [DATA_W-1:0] MAG_1 = DATA_W'(1 << SCALE_SHIFT);
  localparam logic signed [DATA_W-1:0] MAG_3 = DATA_W'(3 << SCALE_SHIFT);
  localparam logic signed [DATA_W-1:0] MAG_5 = DATA_W'(5 << SCALE_SHIFT);

  logic [PHASE_W-1:0]       rot;
  logic signed [DATA_W-1:0] axisMag;
  logic signed [DATA_W-1:0] diagMag;

  assign rot = phase - PHASE_W'(OFFSET);

  always_comb begin
    case (level)
      LVL_UNIT: begin axisMag = MAG_1; diagMag = MAG_1; end
      LVL_LOW:  begin axisMag = MAG_3; diagMag = MAG_1; end
      default:  begin axisMag = MAG_5; diagMag = MAG_3; end
    endcase
  end

  always_comb begin
    case (rot)
      3'd0:       comp = axisMag;
      3'd1, 3'd7: comp = diagMag;
      3'd3, 3'd5: comp = -diagMag;
      3'd4:       comp = -axisMag;
      default:    comp = '0;
    endcase
  end

endmodule

// File: rtl/dpsk_map_point.sv
module dpsk_map_point
  import dpsk_map_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SCALE_SHIFT = 4
) (
  input  logic [PHASE_W-1:0]       phase,
  input  level_e                   level,
  output logic signed [DATA_W-1:0] pointI,
  output logic signed [DATA_W-1:0] pointQ
);

  localparam int N_AXES = 2;
  localparam int QUARTER = PHASE_STEPS / 4;

  logic signed [DATA_W-1:0] comps [N_AXES];

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    dpsk_map_axis #(
      .DATA_W     (DATA_W),
      .SCALE_SHIFT(SCALE_SHIFT),
      .OFFSET     (g * QUARTER)
    ) u_axis (
      .phase(phase),
      .level(level),
      .comp (comps[g])
    );
  end

  assign pointI = comps[0];
  assign pointQ = comps[1];

endmodule

// File: rtl/dpsk_map_dp.sv
module dpsk_map_dp
  import dpsk_map_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SCALE_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mapStrobe_t               strobe,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ,
  output logic                     outValid
);

  logic [PHASE_W-1:0]       phaseReg;
  logic [PHASE_W-1:0]       nextPhase;
  logic signed [DATA_W-1:0] pointI;
  logic signed [DATA_W-1:0] pointQ;

  // Modulo-8 wrap comes from the register width
  assign nextPhase = phaseReg + strobe.step;

  dpsk_map_point #(
    .DATA_W     (DATA_W),
    .SCALE_SHIFT(SCALE_SHIFT)
  ) u_point (
    .phase (nextPhase),
    .level (strobe.level),
    .pointI(pointI),
    .pointQ(pointQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseReg <= '0;
      outI     <= '0;
      outQ     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.advance;
      if (strobe.advance) begin
        phaseReg <= nextPhase;
        outI     <= pointI;
        outQ     <= pointQ;
      end
    end
  end

endmodule

// File: rtl/dpsk_point_mapper.sv
module dpsk_point_mapper
  import dpsk_map_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SCALE_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               symMode,
  input  logic [3:0]               symBits,
  input  logic                     symValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ,
  output logic                     outValid
);

  mapStrobe_t strobe;

  dpsk_map_ctrl u_ctrl (
    .symValid(symValid),
    .symMode (symMode),
    .symBits (symBits),
    .strobe  (strobe)
  );

  dpsk_map_dp #(
    .DATA_W     (DATA_W),
    .SCALE_SHIFT(SCALE_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .outI    (outI),
    .outQ    (outQ),
    .outValid(outValid)
  );

endmodule

// File: rtl/dpsk_point_mapper_chk.sv
module dpsk_point_mapper_chk #(
  parameter int DATA_W      = 8,
  parameter int SCALE_SHIFT = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [1:0]               symMode,
  input logic                     symValid,
  input logic signed [DATA_W-1:0] outI,
  input logic signed [DATA_W-1:0] outQ,
  input logic                     outValid
);

  localparam logic [DATA_W-1:0] M1 = DATA_W'(1 << SCALE_SHIFT);
  localparam logic [DATA_W-1:0] M3 = DATA_W'(3 << SCALE_SHIFT);
  localparam logic [DATA_W-1:0] M5 = DATA_W'(5 << SCALE_SHIFT);

  function automatic logic [DATA_W-1:0] magOf(input logic signed [DATA_W-1:0] v);
    return v[DATA_W-1] ? DATA_W'(-v) : DATA_W'(v);
  endfunction

  // R2: each accepted strobe is followed by a valid pulse
  p_strobe_to_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symMode != 2'b11) |=> outValid);

  // R2: no valid pulse without a strobe
  p_valid_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> !outValid);

  // R2: outputs hold between symbols
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outI) && $stable(outQ)));

  // R9: reserved-mode strobe changes nothing
  p_rsvd_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symMode == 2'b11) |=> (!outValid && $stable(outI) && $stable(outQ)));

  // R10: points lie on an axis or a diagonal
  p_on_grid_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outI == '0 || outQ == '0 || magOf(outI) == magOf(outQ)));

  // R4: axis points use one of the defined magnitudes
  p_axis_levels_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outQ == '0) |-> (magOf(outI) == M1 || magOf(outI) == M3 || magOf(outI) == M5));

  // R5: diagonal points use one of the defined magnitudes
  p_diag_levels_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outI != '0 && outQ != '0) |-> (magOf(outI) == M1 || magOf(outI) == M3));

  // R8: two-bit symbols stay at unit magnitude
  p_unit_two_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(symMode) == 2'b10) |-> (magOf(outI) <= M1 && magOf(outQ) <= M1));

  // R7: three-bit symbols never use the upper amplitude
  p_tri_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(symMode) == 2'b01) |-> (magOf(outI) != M5 && magOf(outQ) != M5));

endmodule

bind dpsk_point_mapper dpsk_point_mapper_chk #(
  .DATA_W     (DATA_W),
  .SCALE_SHIFT(SCALE_SHIFT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .symMode (symMode),
  .symValid(symValid),
  .outI    (outI),
  .outQ    (outQ),
  .outValid(outValid)
);

// File: tb/test_dpsk_point_mapper.sv
`timescale 1ns/1ps
module test_dpsk_point_mapper;

  logic              clk = 1'b0;
  logic              rstN;
  logic [1:0]        symMode;
  logic [3:0]        symBits;
  logic              symValid;
  logic signed [7:0] outI;
  logic signed [7:0] outQ;
  logic              outValid;

  always #4 clk = ~clk;

  dpsk_point_mapper i_dpsk_point_mapper (
    .clk(clk), .rstN(rstN), .symMode(symMode), .symBits(symBits),
    .symValid(symValid), .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  int    testsRun = 0;
  int    testsFailed = 0;
  int    expI[$];
  int    expQ[$];
  string expTag[$];
  int    modelPhase = 0;
  int    lastI = 0;
  int    lastQ = 0;
  bit    done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int stepOf(input logic [1:0] m, input logic [3:0] b);
    if (m == 2'b10) begin
      case (b[1:0])
        2'b00: return 0;
        2'b01: return 2;
        2'b11: return 4;
        default: return 6;
      endcase
    end
    case (b[2:0])
      3'b001: return 0;
      3'b000: return 1;
      3'b010: return 2;
      3'b011: return 3;
      3'b111: return 4;
      3'b110: return 5;
      3'b100: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic pointOf(input int ph, input int lvl, output int ei, output int eq);
    int a;
    int d;
    a = (lvl == 0) ? 16 : (lvl == 1) ? 48 : 80;
    d = (lvl == 2) ? 48 : 16;
    case (ph)
      0: begin ei = a;  eq = 0;  end
      1: begin ei = d;  eq = d;  end
      2: begin ei = 0;  eq = a;  end
      3: begin ei = -d; eq = d;  end
      4: begin ei = -a; eq = 0;  end
      5: begin ei = -d; eq = -d; end
      6: begin ei = 0;  eq = -a; end
      default: begin ei = d; eq = -d; end
    endcase
  endtask

  // Driver: applies one strobe and pushes the expected point
  task automatic sendSym(input logic [1:0] m, input logic [3:0] b, input string tag);
    int lvl;
    int ei;
    int eq;
    @(negedge clk);
    symMode  = m;
    symBits  = b;
    symValid = 1'b1;
    if (m != 2'b11) begin
      modelPhase = (modelPhase + stepOf(m, b)) % 8;
      if (m == 2'b10)      lvl = 0;
      else if (m == 2'b01) lvl = 1;
      else                 lvl = b[3] ? 2 : 1;
      pointOf(modelPhase, lvl, ei, eq);
      expI.push_back(ei);
      expQ.push_back(eq);
      expTag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    symValid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: compares each valid point with the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expI.size() == 0) begin
        check("R2", "unexpected outValid", 1, 0);
      end else begin
        string t;
        int ei;
        int eq;
        t  = expTag.pop_front();
        ei = expI.pop_front();
        eq = expQ.pop_front();
        check(t, "outI", int'(outI), ei);
        check(t, "outQ", int'(outQ), eq);
      end
      lastI = int'(outI);
      lastQ = int'(outQ);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; symValid = 1'b0; symMode = 2'b00; symBits = 4'b0000;
    repeat (3) @(negedge clk);
    check("R1", "outI at reset", int'(outI), 0);
    check("R1", "outQ at reset", int'(outQ), 0);
    check("R1", "outValid at reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: zero change from reset phase lands on phase 0
    sendSym(2'b00, 4'b0001, "R1");
    // R3: every code once, back to back, low amplitude
    sendSym(2'b00, 4'b0001, "R3");
    sendSym(2'b00, 4'b0000, "R3");
    sendSym(2'b00, 4'b0010, "R3");
    sendSym(2'b00, 4'b0011, "R3");
    sendSym(2'b00, 4'b0111, "R3");
    sendSym(2'b00, 4'b0110, "R3");
    sendSym(2'b00, 4'b0100, "R3");
    sendSym(2'b00, 4'b0101, "R3");
    // R4: axis points, both amplitudes
    sendSym(2'b00, 4'b1001, "R4");
    sendSym(2'b00, 4'b1010, "R4");
    sendSym(2'b00, 4'b0010, "R4");
    // R5: diagonal points, both amplitudes
    sendSym(2'b00, 4'b1000, "R5");
    sendSym(2'b00, 4'b0010, "R5");
    sendSym(2'b00, 4'b1111, "R5");
    // R6: wrap forward then backward
    sendSym(2'b00, 4'b0000, "R6");
    sendSym(2'b00, 4'b0101, "R6");
    // R10: walk all eight phases at high amplitude
    for (int k = 0; k < 8; k++) sendSym(2'b00, 4'b1000, "R10");

    // R2: outputs hold and no pulse while idle
    idle(1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2", "outValid while idle", int'(outValid), 0);
      check("R2", "outI held", int'(outI), lastI);
    end

    // R7: three-bit mode, bit 3 ignored, low amplitude
    sendSym(2'b01, 4'b1000, "R7");
    sendSym(2'b01, 4'b1111, "R7");
    sendSym(2'b01, 4'b1010, "R7");
    // R8: two-bit mode from axis and diagonal phases
    sendSym(2'b10, 4'b1100, "R8");
    sendSym(2'b10, 4'b0001, "R8");
    sendSym(2'b00, 4'b0000, "R5");
    sendSym(2'b10, 4'b0011, "R8");
    sendSym(2'b10, 4'b1110, "R8");
    idle(2);

    // R9: reserved strobe ignored
    sendSym(2'b11, 4'b0111, "R9");
    @(negedge clk);
    symValid = 1'b0;
    check("R9", "outValid after reserved", int'(outValid), 0);
    check("R9", "outI after reserved", int'(outI), lastI);
    check("R9", "outQ after reserved", int'(outQ), lastQ);
    sendSym(2'b10, 4'b0000, "R9");
    idle(4);

    check("R2", "points left pending", expI.size(), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule